// File: doc/BRIEF.md
# Sorted-Request Outlet Contention Allocator

This block settles output contention among the input lines of a switching fabric. The request streams reach it one bit per clock on each line, and an upstream sorter has already arranged them so that the destination outlet rises with line index and, for equal outlets, the source port rises. Because of that ordering, every request for a given outlet sits on adjacent lines. The block then picks one winner per outlet by looking only at each line and the line directly below it. The lowest-index line in each run of equal outlets wins.

All lines are framed by a shared `frame_start` strobe. The strobe marks the cycle that carries each line's activity bit. The next ADDR_W cycles carry the destination, most significant bit first, and the ADDR_W cycles after that carry the source port, also most significant bit first. For each line above line 0, a sticky mismatch flag records whether its destination ever differed from the one below it. One cycle after the last source bit, the block drives a grant bit and a grant-valid strobe on every active line. A port controller can therefore append that grant bit directly to the source field it has just forwarded, which forms an acknowledgment of ADDR_W+1 bits.

Top module: `outlet_contention_alloc`

## Requirements
- R1: After a synchronous reset, with `frame_start` low, `grant` and `grant_valid` are all zero.
- R2: When `frame_start` is high in cycle t, `grant_valid`/`grant` are driven only in cycle t+2·ADDR_W+1 and for exactly that one cycle. In that frame, cycle t carries the activity bit, cycles t+1..t+ADDR_W carry the destination and cycles t+ADDR_W+1..t+2·ADDR_W carry the source, each most significant bit first.
- R3: Line 0, when active, always receives grant 0 (winner), whatever the other lines carry.
- R4: An active line k>0 whose lower neighbour k-1 is active with a different destination receives grant 0 (winner).
- R5: An active line k>0 whose lower neighbour k-1 is active with the same destination receives grant 1 (loser).
- R6: A line whose activity bit is 0 has `grant_valid` 0 and `grant` 0 in the grant cycle. An active line directly above an idle line is a winner.
- R7: Source bits have no effect on any grant.
- R8: Every mismatch flag is cleared by `frame_start`, holds its value from the end of the destination field through the grant cycle, and does not carry over into the next frame. A new `frame_start` may coincide with the grant cycle of the previous frame.
- R9: Outside the grant cycle, `grant_valid` and `grant` are zero on every line.
- R10: A difference in any single destination bit position, including only the least significant one, makes the upper line a winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Marks the activity-bit cycle of a new request frame |
| line_bit | input | NUM_LINES | One serial request bit per line |
| grant | output | NUM_LINES | Contention result per line: 0 winner, 1 loser |
| grant_valid | output | NUM_LINES | High on active lines during the grant cycle |

## Verification
Several behaviours are checked by assertions on every clock. The phase sequencer leaves the grant phase after one cycle. Each mismatch flag is cleared by a frame start and stays fixed from the source field through the grant cycle. No valid strobe appears outside the grant phase, and an active line that has seen a mismatch never reports a loss. Only the bench's frames can show that the grant values are correct for whole patterns of activity and destinations. It runs runs of equal outlets, idle gaps, differences confined to the least significant bit, changed source fields and back-to-back frames, and compares each result with an adjacency model computed in the bench.

// File: rtl/ocs_pkg.sv
package ocs_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_DEST  = 2'd1,
      PH_SRC   = 2'd2,
      PH_GRANT = 2'd3
   } phase_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ocs_phase_seq.sv
module ocs_phase_seq
   import ocs_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   frame_start,
   output phase_e phase
);
   localparam int LAST  = 2 * ADDR_W + 1;
   localparam int POS_W = $clog2(LAST + 1);
   localparam logic [POS_W-1:0] POS_LAST     = POS_W'(LAST);
   localparam logic [POS_W-1:0] POS_DEST_END = POS_W'(ADDR_W);

   logic [POS_W-1:0] pos_q;

   always_ff @(posedge clk) begin
      if (rst)
         pos_q <= '0;
      else if (frame_start)
         pos_q <= POS_W'(1);
      else if (pos_q == POS_LAST)
         pos_q <= '0;
      else if (pos_q != '0)
         pos_q <= pos_q + POS_W'(1);
   end

   always_comb begin
      if (pos_q == '0)
         phase = PH_IDLE;
      else if (pos_q <= POS_DEST_END)
         phase = PH_DEST;
      else if (pos_q == POS_LAST)
         phase = PH_GRANT;
      else
         phase = PH_SRC;
   end

   assert_grant_one_cycle_R2 : assert property (@(posedge clk) disable iff (rst)
      (phase == PH_GRANT) |=> (phase != PH_GRANT));

   assert_start_enters_dest_R2 : assert property (@(posedge clk) disable iff (rst)
      frame_start |=> (phase == PH_DEST));

endmodule

// File: rtl/ocs_line_cmp.sv
module ocs_line_cmp
   import ocs_pkg::*;
#(
   parameter bit HAS_BELOW = 1'b1
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   frame_start,
   input  phase_e phase,
   input  logic   bit_self,
   input  logic   bit_below,
   output logic   grant_o,
   output logic   grant_valid_o
);
   logic active_q;

   always_ff @(posedge clk) begin
      if (rst)
         active_q <= 1'b0;
      else if (frame_start)
         active_q <= bit_self;
   end

   assign grant_valid_o = (phase == PH_GRANT) && active_q;

   generate
      if (HAS_BELOW) begin : g_cmp
         logic below_active_q;
         logic mism_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               below_active_q <= 1'b0;
               mism_q         <= 1'b0;
            end else if (frame_start) begin
               below_active_q <= bit_below;
               mism_q         <= 1'b0;
            end else if ((phase == PH_DEST) && (bit_self ^ bit_below)) begin
               mism_q <= 1'b1;
            end
         end

         assign grant_o = grant_valid_o && below_active_q && !mism_q;

         assert_flag_clear_R8 : assert property (@(posedge clk) disable iff (rst)
            frame_start |=> !mism_q);

         assert_flag_hold_R8 : assert property (@(posedge clk) disable iff (rst)
            ((phase == PH_SRC) && !frame_start) |=> $stable(mism_q));

         assert_mismatch_wins_R4 : assert property (@(posedge clk) disable iff (rst)
            (mism_q && (phase == PH_GRANT)) |-> !grant_o);
      end else begin : g_base
         assign grant_o = 1'b0;
      end
   endgenerate

   assert_valid_in_grant_R9 : assert property (@(posedge clk) disable iff (rst)
      (phase != PH_GRANT) |-> (!grant_valid_o && !grant_o));

endmodule

// File: rtl/outlet_contention_alloc.sv
module outlet_contention_alloc
   import ocs_pkg::*;
#(
   parameter int NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 frame_start,
   input  logic [NUM_LINES-1:0] line_bit,
   output logic [NUM_LINES-1:0] grant,
   output logic [NUM_LINES-1:0] grant_valid
);
   localparam int ADDR_W = $clog2(NUM_LINES);

   generate
      if (!is_pow2(NUM_LINES)) begin : g_bad_param
         $fatal(1, "NUM_LINES must be a power of two of at least 2");
      end
   endgenerate

   phase_e phase;

   ocs_phase_seq #(.ADDR_W(ADDR_W)) seq_i (
      .clk         (clk),
      .rst         (rst),
      .frame_start (frame_start),
      .phase       (phase)
   );

   generate
      for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
         if (k == 0) begin : g_first
            ocs_line_cmp #(.HAS_BELOW(1'b0)) cmp_i (
               .clk           (clk),
               .rst           (rst),
               .frame_start   (frame_start),
               .phase         (phase),
               .bit_self      (line_bit[0]),
               .bit_below     (1'b0),
               .grant_o       (grant[0]),
               .grant_valid_o (grant_valid[0])
            );
         end else begin : g_upper
            ocs_line_cmp #(.HAS_BELOW(1'b1)) cmp_i (
               .clk           (clk),
               .rst           (rst),
               .frame_start   (frame_start),
               .phase         (phase),
               .bit_self      (line_bit[k]),
               .bit_below     (line_bit[k-1]),
               .grant_o       (grant[k]),
               .grant_valid_o (grant_valid[k])
            );
         end
      end
   endgenerate

   assert_valid_pulse_R2 : assert property (@(posedge clk) disable iff (rst)
      (|grant_valid) |=> !(|grant_valid));

endmodule

// File: tb/outlet_contention_alloc_tb_top.sv
module outlet_contention_alloc_tb_top;
   localparam int N = 8;
   localparam int W = $clog2(N);

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         frame_start = 1'b0;
   logic [N-1:0] line_bit = '0;
   logic [N-1:0] grant;
   logic [N-1:0] grant_valid;

   int n_tests = 0;
   int n_fail  = 0;

   logic act [N];
   int   dst [N];
   int   src [N];

   always #5 clk = ~clk;

   outlet_contention_alloc #(.NUM_LINES(N)) dut_i (
      .clk(clk), .rst(rst), .frame_start(frame_start),
      .line_bit(line_bit), .grant(grant), .grant_valid(grant_valid)
   );

   function automatic logic exp_loser(input int k);
      if (k == 0) return 1'b0;
      return act[k] && act[k-1] && (dst[k] == dst[k-1]);
   endfunction

   task automatic check(input string req, input logic [N-1:0] actual,
                        input logic [N-1:0] expected);
      n_tests++;
      if (actual !== expected) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, actual, expected);
      end
   endtask

   // Drives one frame; leaves at the negedge inside the grant cycle.
   task automatic run_frame(input string req);
      logic [N-1:0] ev, eg;
      frame_start = 1'b1;
      for (int k = 0; k < N; k++) line_bit[k] = act[k];
      @(negedge clk);
      frame_start = 1'b0;
      for (int b = W - 1; b >= 0; b--) begin
         for (int k = 0; k < N; k++) line_bit[k] = act[k] & dst[k][b];
         @(negedge clk);
         check({req, " R9 no valid in dest"}, grant_valid, '0);
      end
      for (int b = W - 1; b >= 0; b--) begin
         for (int k = 0; k < N; k++) line_bit[k] = act[k] & src[k][b];
         @(negedge clk);
         if (b > 0) check({req, " R9 no valid in src"}, grant_valid | grant, '0);
      end
      line_bit = '0;
      for (int k = 0; k < N; k++) begin
         ev[k] = act[k];
         eg[k] = exp_loser(k);
      end
      check({req, " R2 valid"}, grant_valid, ev);
      check({req, " grant"}, grant, eg);
   endtask

   task automatic idle_cycle();
      frame_start = 1'b0;
      line_bit    = '0;
      @(negedge clk);
      check("R9 idle after grant", grant_valid | grant, '0);
   endtask

   task automatic fill(input logic a, input int d, input int s);
      for (int k = 0; k < N; k++) begin
         act[k] = a; dst[k] = d; src[k] = s;
      end
   endtask

   task automatic random_frame();
      int d = 0;
      for (int k = 0; k < N; k++) begin
         act[k] = ($urandom % 4) != 0;
         if ($urandom % 2 == 1 && d < N - 1) d++;
         dst[k] = d;
         src[k] = $urandom % N;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 reset valid", grant_valid, '0);
      check("R1 reset grant", grant, '0);

      // R5 / R3: all lines request outlet 2
      fill(1'b1, 2, 0);
      for (int k = 0; k < N; k++) src[k] = k;
      run_frame("R5 R3 same outlet");
      idle_cycle();

      // R4: all distinct outlets
      for (int k = 0; k < N; k++) begin act[k] = 1'b1; dst[k] = k; src[k] = N - 1 - k; end
      run_frame("R4 distinct");
      idle_cycle();

      // R10: pairs differing only in LSB
      for (int k = 0; k < N; k++) begin act[k] = 1'b1; dst[k] = k; src[k] = 0; end
      dst[2] = 4; dst[3] = 5; dst[4] = 5; dst[5] = 6; dst[6] = 7; dst[7] = 7;
      run_frame("R10 lsb only");
      idle_cycle();

      // R6: line 0 idle, others same outlet 0; gap at line 4
      fill(1'b1, 0, 3);
      act[0] = 1'b0; act[4] = 1'b0;
      run_frame("R6 idle gaps");
      idle_cycle();

      // R6: all idle
      fill(1'b0, 5, 5);
      run_frame("R6 all idle");
      idle_cycle();

      // R7: same destinations, two different source patterns
      fill(1'b1, 3, 0);
      dst[0] = 1; dst[5] = 6; dst[6] = 6; dst[7] = 6;
      for (int k = 0; k < N; k++) src[k] = k;
      run_frame("R7 src pattern A");
      idle_cycle();
      for (int k = 0; k < N; k++) src[k] = (k * 5 + 3) % N;
      run_frame("R7 src pattern B");
      idle_cycle();

      // R8: back-to-back frames, first all mismatch then all equal
      for (int k = 0; k < N; k++) begin act[k] = 1'b1; dst[k] = k; src[k] = 1; end
      run_frame("R8 b2b first");
      fill(1'b1, 6, 2);
      run_frame("R8 b2b second");
      idle_cycle();

      for (int i = 0; i < 40; i++) begin
         random_frame();
         run_frame("R4 R5 R6 random");
         if (i % 3 == 0) idle_cycle();
      end
      idle_cycle();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule